// File: doc/BRIEF.md
# Debug Match Unit

This block sits next to a processor core and compares every access on four of its buses against a bank of programmable match slots. The buses are numbered: 0 is program fetch, 1 is internal data memory, 2 is external data memory, 3 is the special-function-register space. When a slot matches, the unit latches a halt request for the core and records which slot caused it. The request stays up until the debug host clears it.

Each slot holds the following settings:
- an enable bit;
- a two-bit space code, equal to the bus number above;
- an address;
- a data pattern and a data-compare enable;
- a read enable and a write enable.

On the program space a slot acts as a code breakpoint. It fires on instruction fetches only and never looks at the data. On the three data spaces a slot acts as a watchpoint: it fires on a qualified read or write, with or without a data match. Accesses made by the debugger itself never fire any slot.

The unit also drives two status pins. One shows that the core is running code. The other shows that the debugger is accessing the system. The host programs one slot per cycle through a plain write port.

Top module: `dbg_match_unit`

## Requirements
- R1: After reset the halt request is 0, the hit index is 0, and every slot is disabled, so no access can fire.
- R2: A program-space slot (space code 0) fires on a read strobe on bus 0 at its address. The halt request is high from the clock edge that ends the strobe cycle. The data on bus 0 is never compared for this space, even when data compare is set.
- R3: A slot fires only for an access on the bus whose number equals its space code, and only at an address exactly equal to its own.
- R4: A read fires a slot only when the slot's read enable is set. A write fires it only when its write enable is set.
- R5: On a data space (codes 1 to 3) with data compare set, a slot fires only when the bus data equals its pattern. With data compare clear, any data value matches.
- R6: While the debugger-access input is high, no slot fires.
- R7: Once set, the halt request stays high until the clear input is pulsed. A clear with no fire in the same cycle drops it at the next edge. A fire in the same cycle as a clear keeps it high.
- R8: The hit index captures the lowest-numbered slot that fired in the event that raised the halt request. Further fires while halted leave it unchanged. A clear without a new fire resets it to 0.
- R9: A disabled slot never fires. A slot write takes effect for accesses from the next cycle onward.
- R10: The code-run output equals the core-executing input ANDed with the inverted halt request. The debugger-access output equals the debugger-access input in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_we_i | input | 1 | Slot write strobe |
| cfg_idx_i | input | IDX_W | Slot number being written |
| cfg_en_i | input | 1 | Slot enable |
| cfg_space_i | input | 2 | Space code: 0 program, 1 internal data, 2 external data, 3 SFR |
| cfg_addr_i | input | ADDR_W | Match address |
| cfg_data_i | input | DATA_W | Data pattern |
| cfg_dcmp_i | input | 1 | Data compare enable |
| cfg_rd_i | input | 1 | Read accesses qualify |
| cfg_wr_i | input | 1 | Write accesses qualify |
| bus_rd_i | input | 4 | Read or fetch strobe per bus, bit n for bus n |
| bus_wr_i | input | 4 | Write strobe per bus |
| bus_addr_i | input | 4*ADDR_W | Bus addresses, bus n at bits n*ADDR_W upward |
| bus_data_i | input | 4*DATA_W | Bus data, bus n at bits n*DATA_W upward |
| host_acc_i | input | 1 | Debugger is performing the current access |
| cpu_exec_i | input | 1 | Core is executing an instruction |
| halt_clr_i | input | 1 | Clears the halt request and hit index |
| halt_req_o | output | 1 | Registered halt request |
| hit_idx_o | output | IDX_W | Lowest slot of the first firing event |
| code_run_o | output | 1 | Core running code |
| dbg_acs_o | output | 1 | Debugger access in progress |

## Verification
The halt request and hit index are registered. Their effect is due at the first clock edge after the strobe cycle. The bench drives each access for one cycle starting at a falling edge and samples the outputs at the next falling edge, half a period after that register loads. A slot write becomes active at the rising edge inside its own cycle, so the access that follows it is driven one falling edge later. The code-run and debugger-access outputs have no register in their path, so they are sampled in the same cycle as their inputs.

// File: rtl/dbg_match_pkg.sv
package dbg_match_pkg;
   localparam int NUM_BUSES = 4;

   typedef enum logic [1:0] {
      SP_PROG  = 2'd0,
      SP_IDATA = 2'd1,
      SP_XDATA = 2'd2,
      SP_SFR   = 2'd3
   } space_e;
endpackage

// File: rtl/dbg_match_slot.sv
module dbg_match_slot
   import dbg_match_pkg::*;
#(
   parameter int ADDR_W      = 16,
   parameter int DATA_W      = 8,
   parameter bit DATA_CMP_EN = 1'b1
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic                          load_i,
   input  logic                          en_i,
   input  logic [1:0]                    space_i,
   input  logic [ADDR_W-1:0]             addr_i,
   input  logic [DATA_W-1:0]             data_i,
   input  logic                          dcmp_i,
   input  logic                          rd_i,
   input  logic                          wr_i,
   input  logic [NUM_BUSES-1:0]          bus_rd_i,
   input  logic [NUM_BUSES-1:0]          bus_wr_i,
   input  logic [NUM_BUSES*ADDR_W-1:0]   bus_addr_i,
   input  logic [NUM_BUSES*DATA_W-1:0]   bus_data_i,
   input  logic                          host_acc_i,
   output logic                          fire_o
);
   logic              en_q, dcmp_q, rd_q, wr_q;
   space_e            space_q;
   logic [ADDR_W-1:0] addr_q;
   logic [DATA_W-1:0] data_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         en_q    <= 1'b0;
         space_q <= SP_PROG;
         addr_q  <= '0;
         data_q  <= '0;
         dcmp_q  <= 1'b0;
         rd_q    <= 1'b0;
         wr_q    <= 1'b0;
      end else if (load_i) begin
         en_q    <= en_i;
         space_q <= space_e'(space_i);
         addr_q  <= addr_i;
         data_q  <= data_i;
         dcmp_q  <= dcmp_i;
         rd_q    <= rd_i;
         wr_q    <= wr_i;
      end
   end

   logic              sel_rd, sel_wr, is_prog, addr_hit, type_hit, data_ok;
   logic [ADDR_W-1:0] sel_addr;
   logic [DATA_W-1:0] sel_data;

   always_comb begin
      sel_rd   = bus_rd_i[space_q];
      sel_wr   = bus_wr_i[space_q];
      sel_addr = bus_addr_i[space_q*ADDR_W +: ADDR_W];
      sel_data = bus_data_i[space_q*DATA_W +: DATA_W];
      is_prog  = (space_q == SP_PROG);
      addr_hit = (sel_addr == addr_q);
      // fetches count as reads; program-space writes never qualify
      type_hit = (sel_rd & rd_q) | (sel_wr & wr_q & ~is_prog);
   end

   generate
      if (DATA_CMP_EN) begin : g_dcmp
         assign data_ok = is_prog | ~dcmp_q | (sel_data == data_q);
      end else begin : g_nodcmp
         logic unused_data;
         assign unused_data = ^{sel_data, data_q, dcmp_q};
         assign data_ok = 1'b1;
      end
   endgenerate

   assign fire_o = en_q & ~host_acc_i & type_hit & addr_hit & data_ok;

   // R4: a firing slot always sees a strobe on its own bus
   a_r4_fire_needs_strobe: assert property (@(posedge clk) disable iff (!rst_n)
      fire_o |-> (bus_rd_i[space_q] | bus_wr_i[space_q]));
endmodule

// File: rtl/dbg_first_hit.sv
module dbg_first_hit #(
   parameter int N     = 4,
   parameter int IDX_W = 2
) (
   input  logic [N-1:0]     req_i,
   output logic             any_o,
   output logic [IDX_W-1:0] idx_o
);
   generate
      if (N == 1) begin : g_single
         assign any_o = req_i[0];
         assign idx_o = '0;
      end else begin : g_multi
         always_comb begin
            idx_o = '0;
            for (int k = N - 1; k >= 0; k--) begin
               if (req_i[k]) idx_o = IDX_W'(k);
            end
         end
         assign any_o = |req_i;
      end
   endgenerate

   // R8: the reported slot is one that actually requested
   always_comb begin
      a_r8_idx_valid: assert (!any_o || req_i[idx_o]);
   end
endmodule

// File: rtl/dbg_halt_ctl.sv
module dbg_halt_ctl #(
   parameter int IDX_W = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             fire_i,
   input  logic [IDX_W-1:0] fire_idx_i,
   input  logic             clr_i,
   output logic             halt_o,
   output logic [IDX_W-1:0] hit_idx_o
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         halt_o    <= 1'b0;
         hit_idx_o <= '0;
      end else if (fire_i && (!halt_o || clr_i)) begin
         halt_o    <= 1'b1;
         hit_idx_o <= fire_idx_i;
      end else if (clr_i) begin
         halt_o    <= 1'b0;
         hit_idx_o <= '0;
      end
   end

   // R7: the request holds until cleared
   a_r7_halt_holds: assert property (@(posedge clk) disable iff (!rst_n)
      (halt_o && !clr_i) |=> halt_o);
   // R2: a rising request always follows a firing cycle
   a_r2_halt_cause: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(halt_o) |-> $past(fire_i));
   // R8: the captured index is frozen while halted
   a_r8_idx_frozen: assert property (@(posedge clk) disable iff (!rst_n)
      (halt_o && !clr_i) |=> $stable(hit_idx_o));
endmodule

// File: rtl/dbg_match_unit.sv
module dbg_match_unit
   import dbg_match_pkg::*;
#(
   parameter int NUM_SLOTS   = 4,
   parameter int ADDR_W      = 16,
   parameter int DATA_W      = 8,
   parameter bit DATA_CMP_EN = 1'b1,
   localparam int IDX_W      = (NUM_SLOTS > 1) ? $clog2(NUM_SLOTS) : 1
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic                          cfg_we_i,
   input  logic [IDX_W-1:0]              cfg_idx_i,
   input  logic                          cfg_en_i,
   input  logic [1:0]                    cfg_space_i,
   input  logic [ADDR_W-1:0]             cfg_addr_i,
   input  logic [DATA_W-1:0]             cfg_data_i,
   input  logic                          cfg_dcmp_i,
   input  logic                          cfg_rd_i,
   input  logic                          cfg_wr_i,
   input  logic [3:0]                    bus_rd_i,
   input  logic [3:0]                    bus_wr_i,
   input  logic [4*ADDR_W-1:0]           bus_addr_i,
   input  logic [4*DATA_W-1:0]           bus_data_i,
   input  logic                          host_acc_i,
   input  logic                          cpu_exec_i,
   input  logic                          halt_clr_i,
   output logic                          halt_req_o,
   output logic [IDX_W-1:0]              hit_idx_o,
   output logic                          code_run_o,
   output logic                          dbg_acs_o
);
   initial begin
      a_param_slots: assert (NUM_SLOTS >= 1 && NUM_SLOTS <= 32)
         else $error("NUM_SLOTS out of range");
      a_param_addr: assert (ADDR_W >= 8 && ADDR_W <= 32)
         else $error("ADDR_W out of range");
      a_param_data: assert (DATA_W >= 1 && DATA_W <= 32)
         else $error("DATA_W out of range");
      a_param_buses: assert (NUM_BUSES == 4)
         else $error("bus count mismatch");
   end

   logic [NUM_SLOTS-1:0] fire;
   logic                 any_fire;
   logic [IDX_W-1:0]     first_idx;

   generate
      for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_slot
         dbg_match_slot #(
            .ADDR_W      (ADDR_W),
            .DATA_W      (DATA_W),
            .DATA_CMP_EN (DATA_CMP_EN)
         ) u_slot (
            .clk        (clk),
            .rst_n      (rst_n),
            .load_i     (cfg_we_i && (cfg_idx_i == IDX_W'(s))),
            .en_i       (cfg_en_i),
            .space_i    (cfg_space_i),
            .addr_i     (cfg_addr_i),
            .data_i     (cfg_data_i),
            .dcmp_i     (cfg_dcmp_i),
            .rd_i       (cfg_rd_i),
            .wr_i       (cfg_wr_i),
            .bus_rd_i   (bus_rd_i),
            .bus_wr_i   (bus_wr_i),
            .bus_addr_i (bus_addr_i),
            .bus_data_i (bus_data_i),
            .host_acc_i (host_acc_i),
            .fire_o     (fire[s])
         );
      end
   endgenerate

   dbg_first_hit #(.N(NUM_SLOTS), .IDX_W(IDX_W)) u_first (
      .req_i (fire),
      .any_o (any_fire),
      .idx_o (first_idx)
   );

   dbg_halt_ctl #(.IDX_W(IDX_W)) u_halt (
      .clk        (clk),
      .rst_n      (rst_n),
      .fire_i     (any_fire),
      .fire_idx_i (first_idx),
      .clr_i      (halt_clr_i),
      .halt_o     (halt_req_o),
      .hit_idx_o  (hit_idx_o)
   );

   assign code_run_o = cpu_exec_i & ~halt_req_o;
   assign dbg_acs_o  = host_acc_i;

   // R6: debugger accesses never produce a slot fire
   a_r6_host_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      host_acc_i |-> (fire == '0));
   // R10: a halted core is never reported as running
   a_r10_halt_stops_run: assert property (@(posedge clk) disable iff (!rst_n)
      halt_req_o |-> !code_run_o);
endmodule

// File: tb/dbg_match_unit_bench.sv
module dbg_match_unit_bench;
   localparam int AW = 16;
   localparam int DW = 8;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          cfg_we = 1'b0;
   logic [1:0]    cfg_idx = '0;
   logic          cfg_en = 1'b0;
   logic [1:0]    cfg_space = '0;
   logic [AW-1:0] cfg_addr = '0;
   logic [DW-1:0] cfg_data = '0;
   logic          cfg_dcmp = 1'b0, cfg_rd = 1'b0, cfg_wr = 1'b0;
   logic [3:0]    bus_rd = '0, bus_wr = '0;
   logic [4*AW-1:0] bus_addr = '0;
   logic [4*DW-1:0] bus_data = '0;
   logic          host_acc = 1'b0, cpu_exec = 1'b0, halt_clr = 1'b0;
   logic          halt_req, code_run, dbg_acs;
   logic [1:0]    hit_idx;

   int n_tests = 0;
   int n_fail  = 0;
   bit done    = 1'b0;

   always #5 clk = ~clk;

   dbg_match_unit u_dbg_match_unit (
      .clk(clk), .rst_n(rst_n),
      .cfg_we_i(cfg_we), .cfg_idx_i(cfg_idx), .cfg_en_i(cfg_en),
      .cfg_space_i(cfg_space), .cfg_addr_i(cfg_addr), .cfg_data_i(cfg_data),
      .cfg_dcmp_i(cfg_dcmp), .cfg_rd_i(cfg_rd), .cfg_wr_i(cfg_wr),
      .bus_rd_i(bus_rd), .bus_wr_i(bus_wr), .bus_addr_i(bus_addr),
      .bus_data_i(bus_data), .host_acc_i(host_acc), .cpu_exec_i(cpu_exec),
      .halt_clr_i(halt_clr), .halt_req_o(halt_req), .hit_idx_o(hit_idx),
      .code_run_o(code_run), .dbg_acs_o(dbg_acs)
   );

   // row: [31:30] bus [29] rd [28] wr [27:12] addr [11:4] data [3] host [2] expect halt [1:0] expect index
   localparam int NV = 14;
   localparam logic [31:0] VEC [0:NV-1] = '{
      32'h20100C34, 32'h20101000, 32'h601005A0, 32'h500305A5,
      32'h600305B0, 32'h91234006, 32'hA1234000, 32'hE0090117,
      32'hD0090110, 32'h500305A8, 32'h20100C38, 32'h91234FF6,
      32'h10100000, 32'h600305A5
   };
   localparam string VTAG [0:NV-1] = '{
      "R2", "R3", "R3", "R5", "R5", "R5", "R4",
      "R3", "R4", "R6", "R6", "R5", "R4", "R5"
   };

   task automatic check(input string tag, input int got, input int exp);
      n_tests++;
      if (got != exp) begin
         n_fail++;
         $display("FAIL %s: got %0d expected %0d", tag, got, exp);
      end
   endtask

   task automatic write_slot(input int idx, input bit en, input int sp,
                             input int addr, input int data,
                             input bit dcmp, input bit rd, input bit wr);
      cfg_we = 1'b1; cfg_idx = 2'(idx); cfg_en = en; cfg_space = 2'(sp);
      cfg_addr = AW'(addr); cfg_data = DW'(data); cfg_dcmp = dcmp;
      cfg_rd = rd; cfg_wr = wr;
      @(negedge clk);
      cfg_we = 1'b0;
   endtask

   task automatic drive(input int bus, input bit rd, input bit wr,
                        input int addr, input int data, input bit host);
      bus_rd = '0; bus_wr = '0;
      bus_rd[bus] = rd; bus_wr[bus] = wr;
      bus_addr[bus*AW +: AW] = AW'(addr);
      bus_data[bus*DW +: DW] = DW'(data);
      host_acc = host;
   endtask

   task automatic access(input int bus, input bit rd, input bit wr,
                         input int addr, input int data, input bit host);
      drive(bus, rd, wr, addr, data, host);
      @(negedge clk);
      bus_rd = '0; bus_wr = '0; host_acc = 1'b0;
   endtask

   task automatic clear_halt();
      halt_clr = 1'b1;
      @(negedge clk);
      halt_clr = 1'b0;
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         n_tests++; n_fail++;
         $display("FAIL watchdog: got 1 expected 0");
         $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   end

   initial begin
      cpu_exec = 1'b1;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1: reset state, and no slot armed yet
      check("R1 halt after reset", halt_req, 0);
      check("R1 index after reset", hit_idx, 0);
      access(0, 1'b1, 1'b0, 0, 0, 1'b0);
      check("R1 disabled slots quiet", halt_req, 0);
      check("R10 run while not halted", code_run, 1);

      write_slot(0, 1, 0, 'h0100, 'h00, 1, 1, 0);
      write_slot(1, 1, 1, 'h0030, 'h5A, 1, 1, 1);
      write_slot(2, 1, 2, 'h1234, 'h00, 0, 0, 1);
      write_slot(3, 1, 3, 'h0090, 'h00, 0, 1, 0);

      for (int v = 0; v < NV; v++) begin
         logic [31:0] r;
         r = VEC[v];
         access(int'(r[31:30]), r[29], r[28], int'(r[27:12]), int'(r[11:4]), r[3]);
         check({VTAG[v], " halt"}, halt_req, int'(r[2]));
         check({VTAG[v], " index"}, hit_idx, r[2] ? int'(r[1:0]) : 0);
         clear_halt();
         check({VTAG[v], " cleared"}, halt_req, 0);
      end

      // R7: hold, clear with simultaneous fire, plain clear
      access(0, 1'b1, 1'b0, 'h0100, 0, 1'b0);
      repeat (3) @(negedge clk);
      check("R7 held", halt_req, 1);
      check("R10 stopped while halted", code_run, 0);
      drive(1, 1'b1, 1'b0, 'h0030, 'h5A, 1'b0);
      halt_clr = 1'b1;
      @(negedge clk);
      halt_clr = 1'b0; bus_rd = '0;
      check("R7 fire beats clear", halt_req, 1);
      check("R8 new index on fire with clear", hit_idx, 1);
      clear_halt();
      check("R7 clear drops", halt_req, 0);

      // R8: lowest slot wins, later fires ignored while halted
      write_slot(3, 1, 2, 'h1234, 'h00, 0, 0, 1);
      access(2, 1'b0, 1'b1, 'h1234, 'h77, 1'b0);
      check("R8 lowest of two", hit_idx, 2);
      access(1, 1'b0, 1'b1, 'h0030, 'h5A, 1'b0);
      check("R8 frozen while halted", hit_idx, 2);
      clear_halt();
      check("R8 cleared index", hit_idx, 0);

      // R9: disabling takes effect on the next access
      write_slot(0, 0, 0, 'h0100, 'h00, 0, 1, 0);
      access(0, 1'b1, 1'b0, 'h0100, 0, 1'b0);
      check("R9 disabled slot", halt_req, 0);
      write_slot(0, 1, 0, 'h0100, 'h00, 0, 1, 0);
      access(0, 1'b1, 1'b0, 'h0100, 0, 1'b0);
      check("R9 re-enabled slot", halt_req, 1);
      clear_halt();

      // R10: pass-through status
      host_acc = 1'b1; cpu_exec = 1'b0;
      #1;
      check("R10 debug access shown", dbg_acs, 1);
      check("R10 run follows exec", code_run, 0);
      host_acc = 1'b0;
      #1;
      check("R10 debug access off", dbg_acs, 0);

      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end
endmodule